// File: doc/BRIEF.md
# Debug Module Control and Status Registers

This block is the register core of a hart debug module. A debug transport issues single-word register reads and writes, each tagged with an address. The block keeps a control register that switches the module on, asks the harts to halt and requests a reset of the rest of the system, and drives one output pin from each of those fields. A status register reports whether the harts are unavailable, for example while they are held in reset. A small bank of general data words stands in for the other registers of the module.

Two gates guard the register file. First, while the module-active bit is clear, every write except one to that bit has no effect and every register reads as its reset value. Clearing the bit wipes all other fields. Second, a multi-bit debug-enable input must carry one exact code. Any other code makes reads return zero and drops writes, and the stored contents come back once the code returns. The block's own state is cleared only by its reset input, so it keeps its contents across the system reset it requests.

Top module: `dm_ctrl_status`

## Requirements
- R1: While rst_ni is low and right after it rises, active_o, debug_req_o, ndmreset_o and rsp_valid_o are all 0.
- R2: A write to CTRL_ADDR (with debug enabled) whose bit 0 is 1 sets active_o from the next clock, and one whose bit 0 is 0 clears it. No other access changes active_o.
- R3: While active, a write to CTRL_ADDR with bit 0 set copies bit 31 (halt request) to every bit of debug_req_o from the next clock.
- R4: While active, a write to CTRL_ADDR with bit 0 set copies bit 1 to ndmreset_o. The pin holds that value until a later control write changes it.
- R5: A read of STAT_ADDR returns VERSION in bits [3:0], the OR of unavail_i in bit 8 and the AND of unavail_i in bit 9, as sampled in the request cycle. All other bits read 0.
- R6: While active_o is 0, writes to data words are ignored. A control write taken while inactive sets only the active bit, leaving halt and system reset at 0. Control and data words read 0 while inactive.
- R7: A control write with bit 0 clear returns halt request, system reset and every data word to 0.
- R8: Raising and then lowering ndmreset_o leaves the data words and the active bit unchanged.
- R9: When dbg_en_i differs from EN_ON, every read returns 0 and every write is dropped. Values stored before reappear once dbg_en_i equals EN_ON again.
- R10: Addresses other than CTRL_ADDR, STAT_ADDR and DATA_BASE to DATA_BASE+NUM_DATA-1 read 0, and writes to them change nothing.
- R11: Each request cycle is answered by rsp_valid_o high exactly one clock later, with read data showing the state before that request. Writes answer with data 0.
- R12: Data word i, at address DATA_BASE+i, reads back the last value written to it while active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_en_i | input | EN_W | Debug enable code; only EN_ON enables access |
| unavail_i | input | NUM_HARTS | Per-hart unavailable flag |
| req_valid_i | input | 1 | Register request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response one cycle after a request |
| rsp_rdata_o | output | 32 | Read data of the response |
| active_o | output | 1 | Module-active bit |
| debug_req_o | output | NUM_HARTS | Halt request to each hart |
| ndmreset_o | output | 1 | System (non-debug) reset request |

## Verification
The bench builds the block with three harts and four data words, and an enable code of 4'b0110 instead of the defaults. With three harts the any-unavailable and all-unavailable status bits can differ, and the halt request visibly fans out to several pins. With four data words, addresses just past the bank fall into the unimplemented range. The bench also drives near-miss enable codes and writes from the inactive state, to show that both gates hold back stored data and that the data reappears once the enable code is correct again.

// File: rtl/dm_cs_pkg.sv
package dm_cs_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BIT_ACTIVE = 0;
    localparam int unsigned BIT_NDMRST = 1;
    localparam int unsigned BIT_HALT   = 31;
    localparam int unsigned BIT_ANY_UN = 8;
    localparam int unsigned BIT_ALL_UN = 9;

    typedef struct packed {
        logic halt;
        logic ndmrst;
        logic active;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] rdata;
    } rsp_t;

endpackage

// File: rtl/dm_cs_decode.sv
module dm_cs_decode #(
    parameter int unsigned          ADDR_W    = 7,
    parameter int unsigned          NUM_DATA  = 2,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 7'h10,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 7'h11,
    parameter logic [ADDR_W-1:0]    DATA_BASE = 7'h04,
    localparam int unsigned         IDX_W     = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_ctrl_o,
    output logic              hit_stat_o,
    output logic              hit_data_o,
    output logic [IDX_W-1:0]  data_idx_o
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset     = addr_i - DATA_BASE;
        hit_ctrl_o = (addr_i == CTRL_ADDR);
        hit_stat_o = (addr_i == STAT_ADDR);
        hit_data_o = (addr_i >= DATA_BASE) && (offset < ADDR_W'(NUM_DATA));
        data_idx_o = offset[IDX_W-1:0];
    end

endmodule

// File: rtl/dm_cs_ctrl.sv
module dm_cs_ctrl
    import dm_cs_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_i,
    input  logic  active_bit_i,
    input  logic  halt_bit_i,
    input  logic  ndmrst_bit_i,
    output ctrl_t ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            if (!active_bit_i) begin
                ctrl_d = '0;
            end else if (!ctrl_q.active) begin
                ctrl_d.active = 1'b1;
            end else begin
                ctrl_d.halt   = halt_bit_i;
                ctrl_d.ndmrst = ndmrst_bit_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dm_cs_data.sv
module dm_cs_data
    import dm_cs_pkg::*;
#(
    parameter int unsigned  NUM_DATA = 2,
    localparam int unsigned IDX_W    = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             clear_i,
    input  logic                             wr_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [WORD_W-1:0]                wdata_i,
    output logic [NUM_DATA-1:0][WORD_W-1:0]  words_o
);

    logic [NUM_DATA-1:0][WORD_W-1:0] words_d, words_q;

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
        always_comb begin
            words_d[i] = words_q[i];
            if (clear_i) begin
                words_d[i] = '0;
            end else if (wr_i && (idx_i == IDX_W'(i))) begin
                words_d[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words_o = words_q;

endmodule

// File: rtl/dm_ctrl_status.sv
module dm_ctrl_status
    import dm_cs_pkg::*;
#(
    parameter int unsigned       NUM_HARTS = 1,
    parameter int unsigned       NUM_DATA  = 2,
    parameter int unsigned       ADDR_W    = 7,
    parameter int unsigned       EN_W      = 4,
    parameter logic [EN_W-1:0]   EN_ON     = 4'b1010,
    parameter logic [3:0]        VERSION   = 4'd2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11,
    parameter logic [ADDR_W-1:0] DATA_BASE = 7'h04
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [EN_W-1:0]      dbg_en_i,
    input  logic [NUM_HARTS-1:0] unavail_i,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [WORD_W-1:0]    req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [WORD_W-1:0]    rsp_rdata_o,
    output logic                 active_o,
    output logic [NUM_HARTS-1:0] debug_req_o,
    output logic                 ndmreset_o
);

    localparam int unsigned IDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;

    logic                            en_ok;
    logic                            hit_ctrl, hit_stat, hit_data;
    logic [IDX_W-1:0]                data_idx;
    logic                            wr_any, wr_ctrl, wr_data, clear_all;
    ctrl_t                           ctrl;
    logic [NUM_DATA-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]               rd_word;
    rsp_t                            rsp_d, rsp_q;

    dm_cs_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_DATA (NUM_DATA),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR),
        .DATA_BASE(DATA_BASE)
    ) i_decode (
        .addr_i    (req_addr_i),
        .hit_ctrl_o(hit_ctrl),
        .hit_stat_o(hit_stat),
        .hit_data_o(hit_data),
        .data_idx_o(data_idx)
    );

    always_comb begin
        en_ok     = (dbg_en_i == EN_ON);
        wr_any    = req_valid_i && req_write_i && en_ok;
        wr_ctrl   = wr_any && hit_ctrl;
        wr_data   = wr_any && hit_data && ctrl.active;
        clear_all = wr_ctrl && !req_wdata_i[BIT_ACTIVE];
    end

    dm_cs_ctrl i_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (wr_ctrl),
        .active_bit_i(req_wdata_i[BIT_ACTIVE]),
        .halt_bit_i  (req_wdata_i[BIT_HALT]),
        .ndmrst_bit_i(req_wdata_i[BIT_NDMRST]),
        .ctrl_o      (ctrl)
    );

    dm_cs_data #(
        .NUM_DATA(NUM_DATA)
    ) i_data (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(clear_all),
        .wr_i   (wr_data),
        .idx_i  (data_idx),
        .wdata_i(req_wdata_i),
        .words_o(words)
    );

    always_comb begin
        rd_word = '0;
        if (hit_ctrl) begin
            rd_word[BIT_ACTIVE] = ctrl.active;
            rd_word[BIT_NDMRST] = ctrl.ndmrst;
            rd_word[BIT_HALT]   = ctrl.halt;
        end else if (hit_stat) begin
            rd_word[3:0]        = VERSION;
            rd_word[BIT_ANY_UN] = |unavail_i;
            rd_word[BIT_ALL_UN] = &unavail_i;
        end else if (hit_data && ctrl.active) begin
            rd_word = words[data_idx];
        end
    end

    always_comb begin
        rsp_d.valid = req_valid_i;
        rsp_d.rdata = '0;
        if (req_valid_i && !req_write_i && en_ok) begin
            rsp_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_rdata_o = rsp_q.rdata;
    assign active_o    = ctrl.active;
    assign debug_req_o = {NUM_HARTS{ctrl.halt}};
    assign ndmreset_o  = ctrl.ndmrst;

endmodule

// File: rtl/dm_ctrl_status_chk.sv
module dm_ctrl_status_chk #(
    parameter int unsigned       NUM_HARTS = 1,
    parameter int unsigned       ADDR_W    = 7,
    parameter int unsigned       EN_W      = 4,
    parameter logic [EN_W-1:0]   EN_ON     = 4'b1010,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [EN_W-1:0]      dbg_en_i,
    input logic [NUM_HARTS-1:0] unavail_i,
    input logic                 req_valid_i,
    input logic                 req_write_i,
    input logic [ADDR_W-1:0]    req_addr_i,
    input logic                 rsp_valid_o,
    input logic [31:0]          rsp_rdata_o,
    input logic                 active_o,
    input logic [NUM_HARTS-1:0] debug_req_o,
    input logic                 ndmreset_o
);

    logic ctrl_wr;
    assign ctrl_wr = req_valid_i && req_write_i && (req_addr_i == CTRL_ADDR);

    // R11: a request cycle is answered on the next clock, an idle cycle is not
    p_rsp_timing_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);
    p_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    // R9: a wrong enable code yields a zero response
    p_disabled_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (dbg_en_i != EN_ON)) |=> (rsp_rdata_o == '0));

    // R2, R3, R4: only a control write moves the control pins
    p_ctrl_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> ($stable(active_o) && $stable(debug_req_o) && $stable(ndmreset_o)));

    // R6: an inactive module asserts neither halt nor system reset
    p_inactive_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_o |-> ((debug_req_o == '0) && !ndmreset_o));

    // R5: status all-unavailable bit follows the input
    p_status_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && (req_addr_i == STAT_ADDR) && (dbg_en_i == EN_ON))
        |=> (rsp_rdata_o[9] == $past(&unavail_i)));

endmodule

bind dm_ctrl_status dm_ctrl_status_chk #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W   (ADDR_W),
    .EN_W     (EN_W),
    .EN_ON    (EN_ON),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
) i_dm_ctrl_status_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbg_en_i   (dbg_en_i),
    .unavail_i  (unavail_i),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o),
    .active_o   (active_o),
    .debug_req_o(debug_req_o),
    .ndmreset_o (ndmreset_o)
);

// File: tb/test_dm_ctrl_status.sv
module test_dm_ctrl_status;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NH    = 3;
    localparam int unsigned ND    = 4;
    localparam int unsigned AW    = 7;
    localparam logic [3:0]  ENON  = 4'b0110;
    localparam logic [3:0]  VER   = 4'd2;
    localparam logic [6:0]  A_CTL = 7'h10;
    localparam logic [6:0]  A_STS = 7'h11;
    localparam logic [6:0]  A_DB  = 7'h04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    dbg_en = ENON;
    logic [NH-1:0] unavail = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          active;
    logic [NH-1:0] debug_req;
    logic          ndmreset;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    bit          m_active, m_halt, m_ndm;
    logic [31:0] m_data [ND];

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_ctrl_status #(
        .NUM_HARTS(NH), .NUM_DATA(ND), .ADDR_W(AW), .EN_W(4), .EN_ON(ENON),
        .VERSION(VER), .CTRL_ADDR(A_CTL), .STAT_ADDR(A_STS), .DATA_BASE(A_DB)
    ) i_dm_ctrl_status (
        .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(dbg_en), .unavail_i(unavail),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .active_o(active), .debug_req_o(debug_req), .ndmreset_o(ndmreset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_data(input logic [6:0] a);
        return (a >= A_DB) && (a < A_DB + 7'(ND));
    endfunction

    function automatic logic [31:0] model_read(input logic [6:0] a);
        logic [31:0] r = '0;
        if (dbg_en != ENON) return '0;
        if (a == A_CTL) begin
            r[31] = m_halt; r[1] = m_ndm; r[0] = m_active;
        end else if (a == A_STS) begin
            r[3:0] = VER; r[8] = |unavail; r[9] = &unavail;
        end else if (is_data(a)) begin
            r = m_active ? m_data[a - A_DB] : '0;
        end
        return r;
    endfunction

    function automatic void model_write(input logic [6:0] a, input logic [31:0] d);
        if (dbg_en != ENON) return;
        if (a == A_CTL) begin
            if (!d[0]) begin
                m_active = 0; m_halt = 0; m_ndm = 0;
                for (int i = 0; i < ND; i++) m_data[i] = '0;
            end else if (!m_active) begin
                m_active = 1;
            end else begin
                m_halt = d[31]; m_ndm = d[1];
            end
        end else if (is_data(a) && m_active) begin
            m_data[a - A_DB] = d;
        end
    endfunction

    task automatic pins(input string tag);
        chk({tag, " R2 active"}, 32'(active), 32'(m_active));
        chk({tag, " R3 debug_req"}, 32'(debug_req), m_halt ? 32'((1 << NH) - 1) : 32'd0);
        chk({tag, " R4 ndmreset"}, 32'(ndmreset), 32'(m_ndm));
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic access(input bit wr, input logic [6:0] a, input logic [31:0] d,
                          input string tag);
        logic [31:0] exp_rd;
        exp_rd = wr ? 32'd0 : model_read(a);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) model_write(a, d);
        chk({tag, " R11 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " rdata"}, rsp_rdata, exp_rd);
        pins(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R11 idle no response", 32'(rsp_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_active = 0; m_halt = 0; m_ndm = 0;
        for (int i = 0; i < ND; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        pins("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        pins("R1 after reset");

        // R6: inactive gating
        access(1, A_DB, 32'hDEAD_0001, "R6 data write inactive");
        access(0, A_DB, 0, "R6 data read inactive");
        access(0, A_CTL, 0, "R6 ctrl read inactive");
        access(1, A_CTL, 32'h8000_0003, "R6 first ctrl write sets only active");
        access(0, A_DB, 0, "R6 data not written while inactive");

        // R12: data words
        access(1, A_DB, 32'h1234_5678, "R12 write w0");
        access(1, A_DB + 7'(ND - 1), 32'hCAFE_F00D, "R12 write last");
        access(0, A_DB, 0, "R12 read w0");
        access(0, A_DB + 7'(ND - 1), 0, "R12 read last");

        // R3: halt request
        access(1, A_CTL, 32'h8000_0001, "R3 halt on");
        access(0, A_CTL, 0, "R3 ctrl read");
        access(1, A_CTL, 32'h0000_0001, "R3 halt off");

        // R4/R8: system reset held and harmless
        access(1, A_CTL, 32'h0000_0003, "R4 ndmreset on");
        idle(3);
        pins("R4 ndmreset held");
        access(1, A_CTL, 32'h0000_0001, "R4 ndmreset off");
        access(0, A_DB, 0, "R8 w0 survives");
        access(0, A_DB + 7'(ND - 1), 0, "R8 last survives");

        // R5: status patterns
        unavail = 3'b000; access(0, A_STS, 0, "R5 none unavail");
        unavail = 3'b010; access(0, A_STS, 0, "R5 some unavail");
        unavail = 3'b111; access(0, A_STS, 0, "R5 all unavail");
        unavail = 3'b000;

        // R9: debug enable gate with near-miss codes
        dbg_en = 4'b0000; access(0, A_DB, 0, "R9 read disabled");
        dbg_en = 4'b0111; access(1, A_DB, 32'hBAD0_BAD0, "R9 write disabled");
        dbg_en = 4'b1110; access(0, A_CTL, 0, "R9 ctrl read disabled");
        dbg_en = ENON;    access(0, A_DB, 0, "R9 value reappears");

        // R10: unimplemented addresses
        access(1, 7'h7F, 32'hFFFF_FFFF, "R10 write unimpl");
        access(0, 7'h7F, 0, "R10 read unimpl");
        access(0, A_DB + 7'(ND), 0, "R10 read past bank");
        access(1, A_DB + 7'(ND), 32'h5555_AAAA, "R10 write past bank");
        access(0, A_DB + 7'(ND - 1), 0, "R10 neighbour unchanged");

        // R7: clearing active wipes state
        access(1, A_CTL, 32'h8000_0003, "R7 set halt and ndm");
        access(1, A_CTL, 32'h8000_0002, "R7 clear active");
        access(1, A_CTL, 32'h0000_0001, "R7 reactivate");
        access(0, A_DB, 0, "R7 w0 cleared");
        access(0, A_CTL, 0, "R7 ctrl cleared");

        // constrained random mix
        void'($urandom(32'd1357));
        for (int n = 0; n < 600; n++) begin
            int unsigned pick = $urandom_range(0, 9);
            logic [6:0]  a;
            logic [31:0] d = $urandom;
            bit          w = $urandom_range(0, 1) == 1;
            if (pick < 3) begin
                a = A_CTL;
                d[0] = $urandom_range(0, 7) != 0;
            end else if (pick == 3) a = A_STS;
            else if (pick < 8) a = A_DB + 7'($urandom_range(0, ND));
            else a = 7'($urandom);
            dbg_en  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : ENON;
            unavail = NH'($urandom);
            access(w, a, d, "R12 random");
            if ($urandom_range(0, 7) == 0) idle(1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule